// File: doc/BRIEF.md
# UART Sleep and Wake Controller

This block decides when a UART may stop its core clock to save power and when that clock must come back. It runs from a free-running, always-on clock. Software opts in through two enable bits. Sleep is taken only after a set of idle conditions has held across two consecutive clock edges. The conditions are a quiet receive line, empty transmit storage, an empty receive FIFO and no pending interrupt other than the transmit-holding-empty one.

While asleep, the block watches the receive pin, the modem status inputs and the transmit FIFO write strobe. The pins pass through two-flop synchronizers. A pin counts as changed when its synchronized value differs from the value latched at the moment sleep began. Any such change, any FIFO write, or clearing either enable bit wakes the core on the next clock edge. A write to the baud divisor that arrives during sleep is not applied. It is flagged instead.

Top module: `uart_sleep_ctrl`

## Requirements
- R1: Sleep is entered only when both `enhEn` and `sleepEn` are 1.
- R2: Sleep is entered only when `rxIdle`, `txFifoEmpty` and `txShiftEmpty` are all 1.
- R3: Any set bit of `irqPending` blocks sleep, except bit 1 (transmit-holding-empty), which is ignored.
- R4: Sleep is never entered while `rxFifoEmpty` is 0.
- R5: After reset, `asleep` is 0 and `clkEn` is 1. While `asleep` is 1, `clkEn` is 0.
- R6: While asleep, a change on `rxPin` clears `asleep` three clock edges after the pin changes (two synchronizer stages plus the state register).
- R7: While asleep, a change on any bit of `modemIn` wakes the block with the same three-edge latency.
- R8: While asleep, `txFifoWr` high at a clock edge clears `asleep` at that edge.
- R9: While asleep, clearing `enhEn` or `sleepEn` clears `asleep` at the next clock edge.
- R10: `divWrReq` during sleep raises `divWrBlocked` and keeps `divWrApply` low. When awake, it raises `divWrApply` and keeps `divWrBlocked` low.
- R11: `asleep` rises at the second consecutive clock edge at which all entry conditions hold. After a wake, the conditions must again hold at two fresh edges before sleep returns.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on clock |
| rst_n | input | 1 | Active-low reset |
| enhEn | input | 1 | Enhanced-functions enable bit |
| sleepEn | input | 1 | Sleep enable bit |
| rxIdle | input | 1 | Receive line idle status |
| txFifoEmpty | input | 1 | Transmit FIFO empty |
| txShiftEmpty | input | 1 | Transmit shift register empty |
| rxFifoEmpty | input | 1 | Receive FIFO empty |
| irqPending | input | NUM_IRQ | Pending interrupt sources; bit 1 is transmit-holding-empty |
| rxPin | input | 1 | Receive pin, asynchronous |
| modemIn | input | NUM_MODEM | Modem status pins, asynchronous |
| txFifoWr | input | 1 | Transmit FIFO write strobe |
| divWrReq | input | 1 | Baud divisor write strobe |
| clkEn | output | 1 | Core clock-gate enable |
| asleep | output | 1 | Sleep status |
| divWrApply | output | 1 | Divisor write allowed to take effect |
| divWrBlocked | output | 1 | Divisor write refused during sleep |

## Verification
A table of entry patterns starts from a fully idle set of inputs. Each row breaks one condition at a time: each enable bit, each idle flag, the receive FIFO, and a non-exempt interrupt. One row sets only the exempt interrupt bit. This separates conditions that really gate entry from conditions the block ignores. Each wake source is then tried alone, from a state that would otherwise stay asleep. The checks include a modem bit other than bit 0, so a detector that watched only one pin is caught. Cycle-exact sampling around entry and wake separates a block that enters after one qualifying edge from one that waits for two. It also catches a block that returns to sleep too early after a wake.

// File: rtl/uart_sleep_pkg.sv
package uart_sleep_pkg;
  typedef enum logic {SLP_AWAKE = 1'b0, SLP_ASLEEP = 1'b1} slp_state_t;

  // strobes from control to the pin-watch datapath
  typedef struct packed {
    logic captureRef;  // latch synchronized pin values (sleep entry)
    logic armed;       // report changes only while asleep
  } dp_strobe_t;
endpackage

// File: rtl/uart_sleep_dp.sv
module uart_sleep_dp
  import uart_sleep_pkg::*;
#(
  parameter int NUM_MODEM = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rxPin,
  input  logic [NUM_MODEM-1:0] modemIn,
  input  dp_strobe_t           strb,
  output logic                 pinChange
);
  localparam int PIN_W = NUM_MODEM + 1;

  logic [PIN_W-1:0] pinRaw, syncA, syncB, pinRef, diffVec;

  assign pinRaw = {modemIn, rxPin};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      syncA  <= '1;
      syncB  <= '1;
      pinRef <= '1;
    end else begin
      syncA <= pinRaw;
      syncB <= syncA;
      if (strb.captureRef) pinRef <= syncB;
    end
  end

  for (genvar i = 0; i < PIN_W; i++) begin : g_cmp
    assign diffVec[i] = strb.armed & (syncB[i] ^ pinRef[i]);
  end

  assign pinChange = |diffVec;

  // R6/R7: the reference tracks the pins seen at the capture edge
  p_ref_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $past(strb.captureRef) |-> (pinRef == $past(syncB)));
endmodule

// File: rtl/uart_sleep_fsm.sv
module uart_sleep_fsm
  import uart_sleep_pkg::*;
#(
  parameter int NUM_IRQ = 6,
  parameter int THR_BIT = 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enhEn,
  input  logic               sleepEn,
  input  logic               rxIdle,
  input  logic               txFifoEmpty,
  input  logic               txShiftEmpty,
  input  logic               rxFifoEmpty,
  input  logic [NUM_IRQ-1:0] irqPending,
  input  logic               txFifoWr,
  input  logic               divWrReq,
  input  logic               pinChange,
  output dp_strobe_t         strb,
  output logic               clkEn,
  output logic               asleep,
  output logic               divWrApply,
  output logic               divWrBlocked
);
  localparam logic [NUM_IRQ-1:0] THR_MASK = NUM_IRQ'(1) << THR_BIT;

  slp_state_t state;
  logic enBoth, idleOk, irqOk, enterOk, condQ, goSleep, wake;

  assign enBoth  = enhEn & sleepEn;
  assign idleOk  = rxIdle & txFifoEmpty & txShiftEmpty & rxFifoEmpty;
  assign irqOk   = ~|(irqPending & ~THR_MASK);
  assign enterOk = enBoth & idleOk & irqOk;
  assign goSleep = (state == SLP_AWAKE) & enterOk & condQ;
  assign wake    = (state == SLP_ASLEEP) & (pinChange | txFifoWr | ~enBoth);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= SLP_AWAKE;
      condQ <= 1'b0;
    end else begin
      condQ <= (state == SLP_AWAKE) & ~goSleep & enterOk;
      if (goSleep)   state <= SLP_ASLEEP;
      else if (wake) state <= SLP_AWAKE;
    end
  end

  assign strb.captureRef = goSleep;
  assign strb.armed      = (state == SLP_ASLEEP);
  assign asleep          = (state == SLP_ASLEEP);
  assign clkEn           = (state == SLP_AWAKE);
  assign divWrApply      = divWrReq & (state == SLP_AWAKE);
  assign divWrBlocked    = divWrReq & (state == SLP_ASLEEP);

  p_enter_en_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> $past(enhEn && sleepEn));
  p_enter_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> $past(rxIdle && txFifoEmpty && txShiftEmpty));
  p_enter_irq_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> $past((irqPending & ~THR_MASK) == '0));
  p_enter_rxfifo_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asleep) |-> $past(rxFifoEmpty));
  p_wake_txwr_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && txFifoWr) |=> !asleep);
  p_wake_en_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (asleep && !(enhEn && sleepEn)) |=> !asleep);
  p_no_quick_reentry_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(asleep) |=> !asleep);
endmodule

// File: rtl/uart_sleep_ctrl.sv
module uart_sleep_ctrl
  import uart_sleep_pkg::*;
#(
  parameter int NUM_IRQ   = 6,
  parameter int THR_BIT   = 1,
  parameter int NUM_MODEM = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 enhEn,
  input  logic                 sleepEn,
  input  logic                 rxIdle,
  input  logic                 txFifoEmpty,
  input  logic                 txShiftEmpty,
  input  logic                 rxFifoEmpty,
  input  logic [NUM_IRQ-1:0]   irqPending,
  input  logic                 rxPin,
  input  logic [NUM_MODEM-1:0] modemIn,
  input  logic                 txFifoWr,
  input  logic                 divWrReq,
  output logic                 clkEn,
  output logic                 asleep,
  output logic                 divWrApply,
  output logic                 divWrBlocked
);
  dp_strobe_t strb;
  logic pinChange;

  uart_sleep_fsm #(.NUM_IRQ(NUM_IRQ), .THR_BIT(THR_BIT)) u_fsm (
    .clk(clk), .rst_n(rst_n), .enhEn(enhEn), .sleepEn(sleepEn),
    .rxIdle(rxIdle), .txFifoEmpty(txFifoEmpty), .txShiftEmpty(txShiftEmpty),
    .rxFifoEmpty(rxFifoEmpty), .irqPending(irqPending), .txFifoWr(txFifoWr),
    .divWrReq(divWrReq), .pinChange(pinChange), .strb(strb), .clkEn(clkEn),
    .asleep(asleep), .divWrApply(divWrApply), .divWrBlocked(divWrBlocked)
  );

  uart_sleep_dp #(.NUM_MODEM(NUM_MODEM)) u_dp (
    .clk(clk), .rst_n(rst_n), .rxPin(rxPin), .modemIn(modemIn),
    .strb(strb), .pinChange(pinChange)
  );

  // R5: the core clock is gated exactly while asleep
  p_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    asleep |-> !clkEn);
endmodule

// File: tb/uart_sleep_ctrl_test.sv
module uart_sleep_ctrl_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic enhEn, sleepEn, rxIdle, txFifoEmpty, txShiftEmpty, rxFifoEmpty;
  logic [5:0] irqPending;
  logic rxPin, txFifoWr, divWrReq;
  logic [3:0] modemIn;
  logic clkEn, asleep, divWrApply, divWrBlocked;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  uart_sleep_ctrl uut (.*);

  // {enh, slp, rxIdle, txFE, txSE, rxFE, irq[5:0], expAsleep}
  localparam int NV = 10;
  localparam logic [12:0] VEC [NV] = '{
    13'b1_1_1_1_1_1_000000_1,  // all idle: sleeps
    13'b0_1_1_1_1_1_000000_0,  // R1 enh off
    13'b1_0_1_1_1_1_000000_0,  // R1 sleep bit off
    13'b1_1_0_1_1_1_000000_0,  // R2 rx busy
    13'b1_1_1_0_1_1_000000_0,  // R2 tx fifo data
    13'b1_1_1_1_0_1_000000_0,  // R2 shifter busy
    13'b1_1_1_1_1_0_000000_0,  // R4 rx fifo data
    13'b1_1_1_1_1_1_000010_1,  // R3 thr-only irq ignored
    13'b1_1_1_1_1_1_000100_0,  // R3 other irq blocks
    13'b1_1_1_1_1_1_100000_0   // R3 top irq blocks
  };

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic idleInputs();
    enhEn = 1; sleepEn = 1; rxIdle = 1; txFifoEmpty = 1; txShiftEmpty = 1;
    rxFifoEmpty = 1; irqPending = '0; rxPin = 1; modemIn = '1;
    txFifoWr = 0; divWrReq = 0;
  endtask

  task automatic doReset();
    rst_n = 0;
    repeat (2) @(negedge clk);
    rst_n = 1;
  endtask

  task automatic edges(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic goAsleep();
    idleInputs();
    doReset();
    edges(3);
  endtask

  initial begin
    idleInputs();
    doReset();
    enhEn = 0;
    edges(1);
    chk("R5 reset asleep", asleep, 1'b0);
    chk("R5 reset clkEn", clkEn, 1'b1);

    for (int v = 0; v < NV; v++) begin
      {enhEn, sleepEn, rxIdle, txFifoEmpty, txShiftEmpty, rxFifoEmpty,
       irqPending} = VEC[v][12:1];
      rxPin = 1; modemIn = '1;
      doReset();
      edges(4);
      chk($sformatf("R1/R2/R3/R4 vec%0d asleep", v), asleep, VEC[v][0]);
      chk($sformatf("R5 vec%0d clkEn", v), clkEn, ~VEC[v][0]);
    end

    // R11: two qualifying edges needed
    idleInputs(); rxIdle = 0;
    doReset();
    edges(2);
    rxIdle = 1;
    edges(1);
    chk("R11 one edge", asleep, 1'b0);
    edges(1);
    chk("R11 two edges", asleep, 1'b1);

    // R6: rx pin change
    goAsleep();
    chk("R6 asleep before", asleep, 1'b1);
    rxPin = 0;
    edges(2);
    chk("R6 still asleep in sync", asleep, 1'b1);
    edges(1);
    chk("R6 rx wake", asleep, 1'b0);
    chk("R5 clkEn on wake", clkEn, 1'b1);
    edges(1);
    chk("R11 no quick reentry", asleep, 1'b0);
    edges(1);
    chk("R11 reentry after wake", asleep, 1'b1);

    // R7: modem pin change on bit 2
    goAsleep();
    modemIn[2] = 0;
    edges(3);
    chk("R7 modem wake", asleep, 1'b0);

    // R8: tx fifo write
    goAsleep();
    txFifoWr = 1;
    edges(1);
    txFifoWr = 0;
    chk("R8 txwr wake", asleep, 1'b0);

    // R9: clearing each enable
    goAsleep();
    sleepEn = 0;
    edges(1);
    chk("R9 sleepEn clear wake", asleep, 1'b0);
    goAsleep();
    enhEn = 0;
    edges(1);
    chk("R9 enhEn clear wake", asleep, 1'b0);

    // R10: divisor write gating
    goAsleep();
    divWrReq = 1;
    #1;
    chk("R10 blocked asleep", divWrBlocked, 1'b1);
    chk("R10 no apply asleep", divWrApply, 1'b0);
    edges(1);
    chk("R10 write not a wake source", asleep, 1'b1);
    divWrReq = 0;
    enhEn = 0;
    edges(1);
    divWrReq = 1;
    #1;
    chk("R10 apply awake", divWrApply, 1'b1);
    chk("R10 not blocked awake", divWrBlocked, 1'b0);
    divWrReq = 0;

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule